// File: doc/BRIEF.md
# SPI Master Register Front End

This block is the register bank that a host processor uses to drive a separate SPI master core. The host reaches it through single-cycle register writes and combinational reads on a narrow address bus. The block holds the outgoing frame, up to 40 bits, across two host words. It also holds the clocking setup: the divider exponent, the clock polarity/phase mode and the two stall counts. A packed control word carries the cycle length, the device select code and a start bit. The configuration persists, so software writes it once and then runs many transfers to devices that share those settings.

Software launches a transfer in two steps: it writes the control word with the start bit set, then writes it again with the start bit clear. The 0-to-1 change of the start bit appears on the master's enable line. The block watches the master's done line. On its rising edge the block captures the returned 32-bit frame and raises a sticky done flag. A busy flag covers the time between a forwarded start and the done edge. A start edge that arrives while busy is set is not passed to the master.

Top module: `spi_reg_front`

## Requirements
- R1: After reset every stored register, the enable output, and both status flags are zero.
- R2: Address 0 holds write-data bits 31:0. Address 1 holds bits 39:32 in its bits 7:0, and its other bits read zero. `spi_wr_data` always equals the stored 40-bit frame.
- R3: Address 2 is the configuration word: bits 3:0 divider exponent, 5:4 mode, 11:6 stall start, 17:12 stall stop, all other bits reading zero. It changes only on a write to address 2, and it holds its value across control writes and transfers.
- R4: Address 3 is the control word: bit 0 start, bits 3:1 reserved, bits 7:4 device select, bits 13:8 cycle length. The reserved and upper bits read zero. `spi_sel` and `spi_cycle_len` follow the stored fields.
- R5: A control write with start=1 while the stored start is 0 and the block is idle raises `spi_en` on that clock edge. A control write with start=0 lowers it. Rewriting start=1 while it is already 1 creates no new edge.
- R6: Status bit 1 (busy) sets when a start edge is forwarded and clears on the rising edge of `spi_done`.
- R7: A start edge written while busy is set is not forwarded: `spi_en` stays 0 and busy and done are unchanged.
- R8: Address 4 returns the read-data register. It loads `spi_rd_data` only on the clock where `spi_done` is first seen high, and it keeps that value while `spi_done` stays high or stays low. For a 16-bit frame with an 8-bit command followed by 8 dummy bits, the returned byte is therefore in bits 7:0.
- R9: Status bit 0 (done) sets on the rising edge of `spi_done` and clears when the next start edge is forwarded.
- R10: Writes to address 4 (read data) and address 5 (status) change nothing. Addresses 6 and 7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Single-cycle register write strobe |
| host_addr | input | 3 | Register address |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Combinational read data for host_addr |
| spi_wr_data | output | 40 | Frame for the master, MSB first |
| spi_cycle_len | output | 6 | Frame length in bits |
| spi_sel | output | 4 | Device select code |
| spi_en | output | 1 | Enable; a rising edge starts a transfer |
| spi_mode | output | 2 | Clock polarity and phase |
| spi_clk_div | output | 4 | Divider exponent, sclk = clk / 2^n |
| spi_stall_start | output | 6 | Serial clocks before the stall |
| spi_stall_stop | output | 6 | Serial clocks until the stall ends |
| spi_rd_data | input | 32 | Frame returned by the master |
| spi_done | input | 1 | Rising edge marks the end of a transfer |

## Verification
The bench builds the block with its default widths: a 32-bit host word, a 40-bit frame, a 3-bit address and the 6/4/2/4-bit field sizes. This puts the split of the frame across two words, every unmapped address, and a full-width readback of each packed field within reach. Random register writes and random done pulses run against a bench model and mix the busy, idle and sticky-done states. Directed cases cover a start edge during busy, a done line held high, and writes to the read-only addresses.

// File: rtl/spi_front_pkg.sv
package spi_front_pkg;

    parameter int HOST_W  = 32;
    parameter int WR_W    = 40;
    parameter int RD_W    = 32;
    parameter int ADDR_W  = 3;
    parameter int LEN_W   = 6;
    parameter int SEL_W   = 4;
    parameter int DIV_W   = 4;
    parameter int MODE_W  = 2;
    parameter int STALL_W = 6;

    localparam int WR_HI_W     = WR_W - HOST_W;
    localparam int CTL_RSV_W   = 3;
    localparam int CTL_SEL_LSB = 1 + CTL_RSV_W;
    localparam int CTL_LEN_LSB = CTL_SEL_LSB + SEL_W;
    localparam int CFG_W       = DIV_W + MODE_W + 2 * STALL_W;

    typedef enum logic [ADDR_W-1:0] {
        A_WLO  = 3'd0,
        A_WHI  = 3'd1,
        A_CFG  = 3'd2,
        A_CTL  = 3'd3,
        A_RDD  = 3'd4,
        A_STAT = 3'd5
    } addr_e;

    typedef struct packed {
        logic [STALL_W-1:0] stall_stop;
        logic [STALL_W-1:0] stall_start;
        logic [MODE_W-1:0]  mode;
        logic [DIV_W-1:0]   div;
    } cfg_t;

    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic [SEL_W-1:0] sel;
        logic             start;
    } ctl_t;

    function automatic ctl_t ctl_from_word(input logic [HOST_W-1:0] w);
        ctl_t c;
        c.start = w[0];
        c.sel   = w[CTL_SEL_LSB +: SEL_W];
        c.len   = w[CTL_LEN_LSB +: LEN_W];
        return c;
    endfunction

    function automatic logic [HOST_W-1:0] ctl_to_word(input ctl_t c);
        logic [HOST_W-1:0] w;
        w = '0;
        w[0] = c.start;
        w[CTL_SEL_LSB +: SEL_W] = c.sel;
        w[CTL_LEN_LSB +: LEN_W] = c.len;
        return w;
    endfunction

    function automatic cfg_t cfg_from_word(input logic [HOST_W-1:0] w);
        return cfg_t'(w[CFG_W-1:0]);
    endfunction

    function automatic logic [HOST_W-1:0] cfg_to_word(input cfg_t c);
        return {{(HOST_W-CFG_W){1'b0}}, c};
    endfunction

endpackage

// File: rtl/spi_front_regs.sv
module spi_front_regs
    import spi_front_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [HOST_W-1:0] wdata,
    output logic [WR_W-1:0]   frame_o,
    output cfg_t              cfg_o,
    output ctl_t              ctl_o,
    output logic              start_edge_o,
    output logic              start_clr_o
);

    logic [HOST_W-1:0]  wlo_q;
    logic [WR_HI_W-1:0] whi_q;
    cfg_t               cfg_q;
    ctl_t               ctl_q;
    ctl_t               ctl_new;
    logic               ctl_wr;
    logic               unused_wdata;

    assign unused_wdata = ^wdata;
    assign ctl_new      = ctl_from_word(wdata);
    assign ctl_wr       = wr_en && (addr == A_CTL);
    assign start_edge_o = ctl_wr && ctl_new.start && !ctl_q.start;
    assign start_clr_o  = ctl_wr && !ctl_new.start;

    always_ff @(posedge clk) begin
        if (rst) begin
            wlo_q <= '0;
            whi_q <= '0;
            cfg_q <= '0;
            ctl_q <= '0;
        end else if (wr_en) begin
            case (addr)
                A_WLO: wlo_q <= wdata;
                A_WHI: whi_q <= wdata[WR_HI_W-1:0];
                A_CFG: cfg_q <= cfg_from_word(wdata);
                A_CTL: ctl_q <= ctl_new;
                default: ;
            endcase
        end
    end

    assign frame_o = {whi_q, wlo_q};
    assign cfg_o   = cfg_q;
    assign ctl_o   = ctl_q;

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && addr == A_CFG) |=> $stable(cfg_o)); // R3

    AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && (addr == A_WLO || addr == A_WHI)) |=> $stable(frame_o)); // R2

endmodule

// File: rtl/spi_front_xfer.sv
module spi_front_xfer
    import spi_front_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            start_edge,
    input  logic            start_clr,
    input  logic            done_in,
    input  logic [RD_W-1:0] rd_in,
    output logic            en_o,
    output logic            busy_o,
    output logic            done_o,
    output logic [RD_W-1:0] rd_o
);

    logic            done_d;
    logic            done_rise;
    logic            fwd;
    logic            en_q;
    logic            busy_q;
    logic            flag_q;
    logic [RD_W-1:0] rd_q;

    assign done_rise = done_in && !done_d;
    assign fwd       = start_edge && !busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            done_d <= 1'b0;
            en_q   <= 1'b0;
            busy_q <= 1'b0;
            flag_q <= 1'b0;
            rd_q   <= '0;
        end else begin
            done_d <= done_in;
            if (fwd)            en_q <= 1'b1;
            else if (start_clr) en_q <= 1'b0;
            if (fwd)            busy_q <= 1'b1;
            else if (done_rise) busy_q <= 1'b0;
            if (fwd)            flag_q <= 1'b0;
            else if (done_rise) flag_q <= 1'b1;
            if (done_rise)      rd_q <= rd_in;
        end
    end

    assign en_o   = en_q;
    assign busy_o = busy_q;
    assign done_o = flag_q;
    assign rd_o   = rd_q;

    AST_EN_IDLE_ONLY: assert property (@(posedge clk) disable iff (rst)
        $rose(en_o) |-> $past(!busy_o)); // R7

    AST_EN_MARKS_BUSY: assert property (@(posedge clk) disable iff (rst)
        $rose(en_o) |-> busy_o); // R6

    AST_BUSY_DROPS: assert property (@(posedge clk) disable iff (rst)
        (done_rise && !start_edge) |=> !busy_o); // R6

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done_rise |=> $stable(rd_o)); // R8

    AST_DONE_STICKS: assert property (@(posedge clk) disable iff (rst)
        (done_rise && !fwd) |=> done_o); // R9

    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (start_edge && !busy_o) |=> !done_o); // R9

endmodule

// File: rtl/spi_front_rdmux.sv
module spi_front_rdmux
    import spi_front_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [WR_W-1:0]   frame,
    input  cfg_t              cfg,
    input  ctl_t              ctl,
    input  logic [RD_W-1:0]   rd,
    input  logic              busy,
    input  logic              done,
    output logic [HOST_W-1:0] rdata
);

    always_comb begin
        rdata = '0;
        case (addr)
            A_WLO:  rdata = frame[HOST_W-1:0];
            A_WHI:  rdata = {{(HOST_W-WR_HI_W){1'b0}}, frame[WR_W-1:HOST_W]};
            A_CFG:  rdata = cfg_to_word(cfg);
            A_CTL:  rdata = ctl_to_word(ctl);
            A_RDD:  rdata = HOST_W'(rd);
            A_STAT: rdata = {{(HOST_W-2){1'b0}}, busy, done};
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/spi_reg_front.sv
module spi_reg_front
    import spi_front_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               host_wr,
    input  logic [ADDR_W-1:0]  host_addr,
    input  logic [HOST_W-1:0]  host_wdata,
    output logic [HOST_W-1:0]  host_rdata,
    output logic [WR_W-1:0]    spi_wr_data,
    output logic [LEN_W-1:0]   spi_cycle_len,
    output logic [SEL_W-1:0]   spi_sel,
    output logic               spi_en,
    output logic [MODE_W-1:0]  spi_mode,
    output logic [DIV_W-1:0]   spi_clk_div,
    output logic [STALL_W-1:0] spi_stall_start,
    output logic [STALL_W-1:0] spi_stall_stop,
    input  logic [RD_W-1:0]    spi_rd_data,
    input  logic               spi_done
);

    cfg_t            cfg;
    ctl_t            ctl;
    logic            start_edge;
    logic            start_clr;
    logic            busy;
    logic            done_flag;
    logic [RD_W-1:0] rd_reg;

    spi_front_regs u_regs (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (host_wr),
        .addr         (host_addr),
        .wdata        (host_wdata),
        .frame_o      (spi_wr_data),
        .cfg_o        (cfg),
        .ctl_o        (ctl),
        .start_edge_o (start_edge),
        .start_clr_o  (start_clr)
    );

    spi_front_xfer u_xfer (
        .clk        (clk),
        .rst        (rst),
        .start_edge (start_edge),
        .start_clr  (start_clr),
        .done_in    (spi_done),
        .rd_in      (spi_rd_data),
        .en_o       (spi_en),
        .busy_o     (busy),
        .done_o     (done_flag),
        .rd_o       (rd_reg)
    );

    spi_front_rdmux u_mux (
        .addr  (host_addr),
        .frame (spi_wr_data),
        .cfg   (cfg),
        .ctl   (ctl),
        .rd    (rd_reg),
        .busy  (busy),
        .done  (done_flag),
        .rdata (host_rdata)
    );

    assign spi_cycle_len   = ctl.len;
    assign spi_sel         = ctl.sel;
    assign spi_mode        = cfg.mode;
    assign spi_clk_div     = cfg.div;
    assign spi_stall_start = cfg.stall_start;
    assign spi_stall_stop  = cfg.stall_stop;

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!spi_en && spi_wr_data == '0)); // R1

endmodule

// File: tb/tb_spi_reg_front.sv
module tb_spi_reg_front;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr = 1'b0;
    logic [2:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic [39:0] spi_wr_data;
    logic [5:0]  spi_cycle_len;
    logic [3:0]  spi_sel;
    logic        spi_en;
    logic [1:0]  spi_mode;
    logic [3:0]  spi_clk_div;
    logic [5:0]  spi_stall_start;
    logic [5:0]  spi_stall_stop;
    logic [31:0] spi_rd_data = '0;
    logic        spi_done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_reg_front dut (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .spi_wr_data(spi_wr_data), .spi_cycle_len(spi_cycle_len),
        .spi_sel(spi_sel), .spi_en(spi_en), .spi_mode(spi_mode),
        .spi_clk_div(spi_clk_div), .spi_stall_start(spi_stall_start),
        .spi_stall_stop(spi_stall_stop), .spi_rd_data(spi_rd_data),
        .spi_done(spi_done)
    );

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    // bench model
    logic [31:0] m_wlo;
    logic [7:0]  m_whi;
    logic [17:0] m_cfg;
    logic        m_start;
    logic [3:0]  m_sel;
    logic [5:0]  m_len;
    logic        m_en, m_busy, m_done;
    logic [31:0] m_rd;

    task automatic model_reset();
        m_wlo = '0; m_whi = '0; m_cfg = '0; m_start = 0; m_sel = '0; m_len = '0;
        m_en = 0; m_busy = 0; m_done = 0; m_rd = '0;
    endtask

    function automatic logic [31:0] exp_read(input int a);
        case (a)
            0: return m_wlo;
            1: return {24'b0, m_whi};
            2: return {14'b0, m_cfg};
            3: return {18'b0, m_len, m_sel, 3'b000, m_start};
            4: return m_rd;
            5: return {30'b0, m_busy, m_done};
            default: return 32'b0;
        endcase
    endfunction

    function automatic string req_of(input int a);
        case (a)
            0, 1: return "R2";
            2: return "R3";
            3: return "R4";
            4: return "R8";
            5: return "R6";
            default: return "R10";
        endcase
    endfunction

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic host_write(input int a, input logic [31:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = 3'(a); host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
        case (a)
            0: m_wlo = d;
            1: m_whi = d[7:0];
            2: m_cfg = d[17:0];
            3: begin
                if (d[0] && !m_start && !m_busy) begin
                    m_en = 1; m_busy = 1; m_done = 0;
                end else if (!d[0]) begin
                    m_en = 0;
                end
                m_start = d[0]; m_sel = d[7:4]; m_len = d[13:8];
            end
            default: ;
        endcase
    endtask

    task automatic done_pulse(input logic [31:0] v);
        @(negedge clk);
        spi_done = 1'b1; spi_rd_data = v;
        @(negedge clk);
        spi_done = 1'b0; spi_rd_data = ~v;
        m_rd = v; m_done = 1; m_busy = 0;
    endtask

    task automatic done_hold(input logic [31:0] v1, input logic [31:0] v2);
        @(negedge clk);
        spi_done = 1'b1; spi_rd_data = v1;
        @(negedge clk);
        spi_rd_data = v2;
        @(negedge clk);
        spi_done = 1'b0;
        m_rd = v1; m_done = 1; m_busy = 0;
    endtask

    task automatic check_all(input string tag);
        chk("R2", {tag, " frame"}, 64'(spi_wr_data), 64'({m_whi, m_wlo}));
        chk("R4", {tag, " len"}, 64'(spi_cycle_len), 64'(m_len));
        chk("R4", {tag, " sel"}, 64'(spi_sel), 64'(m_sel));
        chk("R5", {tag, " en"}, 64'(spi_en), 64'(m_en));
        chk("R3", {tag, " cfg pins"},
            64'({spi_stall_stop, spi_stall_start, spi_mode, spi_clk_div}), 64'(m_cfg));
        for (int a = 0; a < 8; a++) begin
            @(negedge clk);
            host_addr = 3'(a);
            #1;
            chk(req_of(a), $sformatf("%s read addr %0d", tag, a), 64'(host_rdata), 64'(exp_read(a)));
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'h5A17);
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1", "en after reset", 64'(spi_en), 64'(0));
        check_all("R1 reset");

        // R2 frame split and upper-bit masking
        host_write(0, 32'hDEAD_BEEF);
        host_write(1, 32'hFFFF_FFA5);
        check_all("R2 frame");

        // R3 config layout: stall_stop=0x2A stall_start=0x15 mode=2 div=3, upper junk
        host_write(2, 32'hFFFC_0000 | {14'b0, 6'h2A, 6'h15, 2'd2, 4'd3});
        chk("R3", "stall_stop", 64'(spi_stall_stop), 64'(6'h2A));
        chk("R3", "stall_start", 64'(spi_stall_start), 64'(6'h15));
        chk("R3", "mode", 64'(spi_mode), 64'(2));
        chk("R3", "div", 64'(spi_clk_div), 64'(3));

        // R4 control with reserved and upper bits set, start=0
        host_write(3, 32'hFFFF_C000 | {18'b0, 6'd16, 4'd2, 3'b111, 1'b0});
        check_all("R4 ctl");

        // R5 start edge forwarded
        host_write(3, {18'b0, 6'd16, 4'd2, 3'b000, 1'b1});
        chk("R5", "en rises", 64'(spi_en), 64'(1));
        check_all("R5 start");
        host_write(3, {18'b0, 6'd16, 4'd2, 3'b000, 1'b0});
        chk("R5", "en falls", 64'(spi_en), 64'(0));
        chk("R6", "busy after clear", 64'(m_busy), 64'(1));
        check_all("R6 busy");

        // R7 start while busy is dropped
        host_write(3, {18'b0, 6'd18, 4'd0, 3'b000, 1'b1});
        chk("R7", "en stays low", 64'(spi_en), 64'(0));
        host_write(3, {18'b0, 6'd18, 4'd0, 3'b000, 1'b0});
        check_all("R7 dropped");

        // R8 capture: byte in 7:0 of a 16-bit read
        done_pulse(32'h0000_00C3);
        check_all("R8 capture");
        // R3 configuration survived the transfer
        chk("R3", "cfg kept", 64'({spi_stall_stop, spi_stall_start, spi_mode, spi_clk_div}),
            64'({6'h2A, 6'h15, 2'd2, 4'd3}));

        // R8 done held high: second value not captured
        done_hold(32'h1234_5678, 32'h8765_4321);
        check_all("R8 held");

        // R10 writes to read-only addresses ignored
        host_write(4, 32'hFFFF_FFFF);
        host_write(5, 32'hFFFF_FFFF);
        host_write(6, 32'hFFFF_FFFF);
        check_all("R10 ignored");

        // R9 sticky done clears on next forwarded start
        chk("R9", "done set", 64'(m_done), 64'(1));
        host_write(3, {18'b0, 6'd8, 4'd3, 3'b000, 1'b1});
        check_all("R9 cleared");
        // R5 rewriting start=1 gives no new edge
        host_write(3, {18'b0, 6'd8, 4'd3, 3'b000, 1'b1});
        check_all("R5 rewrite");

        // random phase
        for (int i = 0; i < 300; i++) begin
            int op;
            op = int'($urandom_range(0, 9));
            if (op < 2) begin
                done_pulse($urandom);
            end else if (op < 5) begin
                host_write(3, $urandom);
            end else begin
                host_write(int'($urandom_range(0, 7)), $urandom);
            end
            check_all("rand");
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule